// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block lives inside a synchronous DRAM device model. For each cycle of a read or write burst it supplies the column address. It keeps a small mode register that sets the burst length, the column ordering, the single-beat write option and the CAS latency. A column command loads a start column and begins a burst. The block then walks the columns in sequential or interleaved order, flags the final beat, and stops early when a new column command or a same-bank precharge arrives.

A burst that carries auto-precharge cannot be cut short. A new command or a precharge that arrives during such a burst is dropped and reported with a one-cycle pulse. When a precharge stops a read, the block signals how long the data tail still runs. This depends on the CAS latency that was in effect when the read started.

Top module: `sdram_burst_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge: `col_addr`, `burst_active`, `last_beat`, `illegal_interrupt` and `tail_valid`. The mode register is also cleared to zero.
- R2: A column command (`cmd_valid`) that is not blocked by R11 is accepted. In the cycle after it, `burst_active` is 1 and `col_addr` equals `cmd_col` (beat 0).
- R3: Mode bits [2:0] set the burst length L: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. An uninterrupted burst keeps `burst_active` high for exactly L cycles. `last_beat` is high only in the L-th cycle. `burst_active` falls in the cycle after that, unless a new burst was accepted.
- R4: With mode bit 3 at 0 (sequential), beat k of a length-L burst keeps the column bits above log2(L). Its low log2(L) bits are (start + k) mod L.
- R5: With mode bit 3 at 1 (interleaved), the low log2(L) bits of beat k are the start's low bits XOR k. For L of 1 or 2, this matches the sequential result.
- R6: Code 111 with mode bit 3 at 0 gives a full-page burst. Beat k is (start + k) mod 256, so the column wraps from 255 to 0. `last_beat` never rises, and the burst runs until it is interrupted. Codes 100, 101 and 110, and code 111 with bit 3 at 1, act as length 1.
- R7: With mode bit 9 at 1, every write burst is one beat long. Read bursts keep the programmed length.
- R8: A new accepted command during a burst ends the old burst at once. In the next cycle the new burst is at beat 0 of the new column.
- R9: `pre_valid` during a burst without auto-precharge makes `burst_active` 0 in the next cycle. When `pre_valid` and `cmd_valid` are high together, the command takes priority and the precharge is ignored. A precharge while idle has no effect.
- R10: When a precharge stops a read, `tail_valid` is high for the cycles that follow. It lasts 2 cycles if mode bits [6:4] were 011 (CAS latency 3) when the read was accepted, and 1 cycle otherwise. Stopping a write gives no tail.
- R11: During a burst accepted with `cmd_auto_pre` high, a `cmd_valid` or a `pre_valid` does not affect the burst. `illegal_interrupt` is high for one cycle in the cycle after it.
- R12: `mode_load` writes `mode_in` into the mode register at the clock edge. A burst already running keeps the settings it captured when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Write the mode register |
| mode_in | input | 10 | New mode value: [2:0] length, [3] order, [6:4] CAS latency, [9] single write |
| cmd_valid | input | 1 | Column command (read or write) for this bank |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_auto_pre | input | 1 | Command carries auto-precharge |
| cmd_col | input | COL_W | Start column |
| pre_valid | input | 1 | Precharge of this bank |
| col_addr | output | COL_W | Column of the current beat |
| burst_active | output | 1 | A beat is in progress this cycle |
| last_beat | output | 1 | Current beat is the final one |
| illegal_interrupt | output | 1 | An interrupt was refused during an auto-precharge burst |
| tail_valid | output | 1 | Read data still valid after a precharge stop |

## Verification
Several rules are checked by assertions on every cycle. These are:
- the load of beat 0 on acceptance;
- `last_beat` only inside a burst, and the burst ending after it;
- the stop on a precharge;
- the flag and the continued burst on a refused interrupt;
- fixed upper column bits within a finite burst;
- no `last_beat` in full-page mode.

Other behaviour can only be shown by the bench's scenarios, checked against a model written from the rules above. This covers the exact column sequences for each order and length, the full-page wrap, the single-beat write option, the tail length for each CAS latency, and mode changes that take effect only at the next command.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic [9:0]       mode_in,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             cmd_auto_pre,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             pre_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             burst_active,
  output logic             last_beat,
  output logic             illegal_interrupt,
  output logic             tail_valid
);
  localparam logic [1:0] TAIL_CL3 = 2'd2;
  localparam logic [1:0] TAIL_CL2 = 2'd1;

  logic [9:0]       mode_q;
  logic [COL_W-1:0] start_q, beat_q, mask_q, col_q;
  logic             ilv_q, full_q, ap_q, rd_q, cl3_q, active_q, last_q, illegal_q;
  logic [1:0]       tail_q;

  wire ap_busy   = active_q & ap_q;
  wire accept    = cmd_valid & ~ap_busy;
  wire stop      = ~cmd_valid & pre_valid & active_q & ~ap_q;
  wire single_wr = cmd_write & mode_q[9];

  logic [COL_W-1:0] cmd_mask;
  logic             cmd_full;
  always_comb begin
    cmd_full = 1'b0;
    cmd_mask = '0;
    if (!single_wr) begin
      case (mode_q[2:0])
        3'b001:  cmd_mask = COL_W'(1);
        3'b010:  cmd_mask = COL_W'(3);
        3'b011:  cmd_mask = COL_W'(7);
        3'b111:  if (!mode_q[3]) begin cmd_full = 1'b1; cmd_mask = '1; end
        default: cmd_mask = '0;
      endcase
    end
  end

  logic [COL_W-1:0] s_n, n_n, m_n;
  logic             i_n, f_n, act_n;
  always_comb begin
    s_n = start_q; n_n = beat_q; m_n = mask_q;
    i_n = ilv_q;   f_n = full_q; act_n = active_q;
    if (accept) begin
      s_n = cmd_col; n_n = '0; m_n = cmd_mask;
      i_n = mode_q[3]; f_n = cmd_full; act_n = 1'b1;
    end else if (stop) begin
      act_n = 1'b0;
    end else if (active_q) begin
      if (last_q) act_n = 1'b0;
      else        n_n = beat_q + 1'b1;
    end
  end

  wire [COL_W-1:0] step_col = i_n ? (s_n ^ n_n) : (s_n + n_n);
  wire [COL_W-1:0] col_n    = (s_n & ~m_n) | (step_col & m_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; start_q <= '0; beat_q <= '0; mask_q <= '0; col_q <= '0;
      ilv_q <= 1'b0; full_q <= 1'b0; ap_q <= 1'b0; rd_q <= 1'b0; cl3_q <= 1'b0;
      active_q <= 1'b0; last_q <= 1'b0; illegal_q <= 1'b0; tail_q <= '0;
    end else begin
      if (mode_load) mode_q <= mode_in;
      start_q  <= s_n;
      beat_q   <= n_n;
      mask_q   <= m_n;
      ilv_q    <= i_n;
      full_q   <= f_n;
      active_q <= act_n;
      if (accept) begin
        ap_q  <= cmd_auto_pre;
        rd_q  <= ~cmd_write;
        cl3_q <= (mode_q[6:4] == 3'b011);
      end
      if (act_n) col_q <= col_n;
      last_q    <= act_n & ~f_n & (n_n == m_n);
      illegal_q <= ap_busy & (cmd_valid | pre_valid);
      if (stop && rd_q)       tail_q <= cl3_q ? TAIL_CL3 : TAIL_CL2;
      else if (tail_q != 2'd0) tail_q <= tail_q - 2'd1;
    end
  end

  assign col_addr          = col_q;
  assign burst_active      = active_q;
  assign last_beat         = last_q;
  assign illegal_interrupt = illegal_q;
  assign tail_valid        = tail_q != 2'd0;

  assert_accept_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !(burst_active && ap_q)) |=> (burst_active && col_addr == $past(cmd_col)));
  assert_last_inside_R3: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> burst_active);
  assert_last_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !(cmd_valid && !ap_q)) |=> !burst_active);
  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    (burst_active && !full_q && !last_beat && !cmd_valid && !pre_valid)
      |=> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));
  assert_full_no_last_R6: assert property (@(posedge clk) disable iff (rst)
    (burst_active && full_q) |-> !last_beat);
  assert_pre_stops_R9: assert property (@(posedge clk) disable iff (rst)
    (burst_active && !ap_q && pre_valid && !cmd_valid) |=> !burst_active);
  assert_refused_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (burst_active && ap_q && (cmd_valid || pre_valid)) |=> illegal_interrupt);
  assert_refused_keeps_R11: assert property (@(posedge clk) disable iff (rst)
    (burst_active && ap_q && !last_beat) |=> burst_active);
endmodule

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_burst_seq_test;
  logic       clk = 1'b0;
  logic       rst, mode_load, cmd_valid, cmd_write, cmd_auto_pre, pre_valid;
  logic [9:0] mode_in;
  logic [7:0] cmd_col, col_addr;
  logic       burst_active, last_beat, illegal_interrupt, tail_valid;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdram_burst_seq #(.COL_W(8)) uut (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_in(mode_in),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_auto_pre(cmd_auto_pre),
    .cmd_col(cmd_col), .pre_valid(pre_valid), .col_addr(col_addr),
    .burst_active(burst_active), .last_beat(last_beat),
    .illegal_interrupt(illegal_interrupt), .tail_valid(tail_valid));

  // reference model state
  logic [9:0] m_mode;
  int m_start, m_k, m_len, m_tail, m_col;
  bit m_active, m_full, m_ilv, m_ap, m_rd, m_cl3, m_illegal;

  function automatic int len_of(logic [9:0] md, bit wr, output bit full);
    full = 0;
    if (wr && md[9]) return 1;
    case (md[2:0])
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: if (!md[3]) begin full = 1; return 256; end
      default: ;
    endcase
    return 1;
  endfunction

  function automatic int exp_col(int start, int k, int len, bit full, bit ilv);
    int base, off;
    if (full) return (start + k) % 256;
    base = start - (start % len);
    off  = ilv ? ((start % len) ^ k) : (((start % len) + k) % len);
    return base + off;
  endfunction

  task automatic model_reset();
    m_mode = '0; m_start = 0; m_k = 0; m_len = 1; m_tail = 0; m_col = 0;
    m_active = 0; m_full = 0; m_ilv = 0; m_ap = 0; m_rd = 0; m_cl3 = 0; m_illegal = 0;
  endtask

  task automatic model_step(bit ml, logic [9:0] mv, bit cv, bit cw, bit cap, int ccol, bit pv);
    bit acc, stp, fl;
    m_illegal = m_active && m_ap && (cv || pv);
    acc = cv && !(m_active && m_ap);
    stp = !cv && pv && m_active && !m_ap;
    if (stp && m_rd) m_tail = m_cl3 ? 2 : 1;
    else if (m_tail > 0) m_tail--;
    if (acc) begin
      m_len = len_of(m_mode, cw, fl); m_full = fl;
      m_start = ccol; m_k = 0; m_active = 1;
      m_ilv = m_mode[3]; m_ap = cap; m_rd = !cw; m_cl3 = (m_mode[6:4] == 3'b011);
    end else if (stp) m_active = 0;
    else if (m_active) begin
      if (!m_full && m_k == m_len - 1) m_active = 0;
      else m_k++;
    end
    if (m_active) m_col = exp_col(m_start, m_k, m_len, m_full, m_ilv);
    if (ml) m_mode = mv;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "burst_active", burst_active, m_active);
    check(tag, "col_addr", col_addr, m_col);
    check(tag, "last_beat", last_beat, m_active && !m_full && (m_k == m_len - 1));
    check(tag, "illegal_interrupt", illegal_interrupt, m_illegal);
    check(tag, "tail_valid", tail_valid, m_tail != 0);
  endtask

  task automatic tick(string tag, bit ml, logic [9:0] mv, bit cv, bit cw, bit cap, int ccol, bit pv);
    @(negedge clk);
    mode_load = ml; mode_in = mv; cmd_valid = cv; cmd_write = cw;
    cmd_auto_pre = cap; cmd_col = 8'(ccol); pre_valid = pv;
    model_step(ml, mv, cv, cw, cap, ccol, pv);
    @(posedge clk); #1;
    compare_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag, 0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_mode(string tag, logic [9:0] mv);
    tick(tag, 1, mv, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    rst = 1; mode_load = 0; mode_in = '0; cmd_valid = 0; cmd_write = 0;
    cmd_auto_pre = 0; cmd_col = '0; pre_valid = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 reset");
    @(negedge clk); rst = 0;

    // R3/R4: length 4 sequential from 0x46 -> 46,47,44,45
    set_mode("R3", 10'b0_0_0_010_0_010);
    tick("R4 seq len4", 0, '0, 1, 0, 0, 8'h46, 0);
    idle("R3 R4 len4 run", 5);
    // R5: interleaved length 8
    set_mode("R5", 10'b0_0_0_011_1_011);
    tick("R5 ilv len8", 0, '0, 1, 0, 0, 8'h35, 0);
    idle("R5 ilv run", 9);
    // R5: interleaved length 2 equals sequential
    set_mode("R5", 10'b0_0_0_010_1_001);
    tick("R5 ilv len2", 0, '0, 1, 0, 0, 8'h9B, 0);
    idle("R5 len2 run", 3);
    // R6: full page wraps 255 -> 0, then stopped by precharge
    set_mode("R6", 10'b0_0_0_010_0_111);
    tick("R6 full", 0, '0, 1, 1, 0, 8'hFD, 0);
    idle("R6 wrap", 6);
    tick("R9 stop full", 0, '0, 0, 0, 0, 0, 1);
    idle("R9 idle", 2);
    // R6: code 111 with interleave acts as length 1
    set_mode("R6", 10'b0_0_0_010_1_111);
    tick("R6 ilv 111", 0, '0, 1, 0, 0, 8'h20, 0);
    idle("R6 len1", 2);
    // R7: single-beat writes, full-length reads
    set_mode("R7", 10'b1_0_0_010_0_011);
    tick("R7 write", 0, '0, 1, 1, 0, 8'h10, 0);
    idle("R7 write single", 2);
    tick("R7 read", 0, '0, 1, 0, 0, 8'h10, 0);
    idle("R7 read len8", 9);
    // R8: new command mid burst
    set_mode("R8", 10'b0_0_0_010_0_011);
    tick("R8 first", 0, '0, 1, 0, 0, 8'h40, 0);
    idle("R8 run", 2);
    tick("R8 second", 0, '0, 1, 0, 0, 8'h83, 0);
    idle("R8 run2", 9);
    // R10: read stop at CAS latency 3 and 2; write stop no tail
    set_mode("R10", 10'b0_0_0_011_0_011);
    tick("R10 cl3 read", 0, '0, 1, 0, 0, 8'h00, 0);
    idle("R10 run", 2);
    tick("R10 cl3 stop", 0, '0, 0, 0, 0, 0, 1);
    idle("R10 tail cl3", 3);
    set_mode("R10", 10'b0_0_0_010_0_011);
    tick("R10 cl2 read", 0, '0, 1, 0, 0, 8'h00, 0);
    tick("R10 cl2 stop", 0, '0, 0, 0, 0, 0, 1);
    idle("R10 tail cl2", 2);
    tick("R10 write", 0, '0, 1, 1, 0, 8'h00, 0);
    tick("R10 write stop", 0, '0, 0, 0, 0, 0, 1);
    idle("R10 no tail", 2);
    // R9: simultaneous command wins; idle precharge ignored
    tick("R9 start", 0, '0, 1, 0, 0, 8'h50, 0);
    tick("R9 cmd wins", 0, '0, 1, 0, 0, 8'h60, 1);
    idle("R9 run", 9);
    tick("R9 idle pre", 0, '0, 0, 0, 0, 0, 1);
    // R11: auto-precharge burst refuses interrupts
    tick("R11 ap start", 0, '0, 1, 0, 1, 8'h70, 0);
    tick("R11 refuse cmd", 0, '0, 1, 0, 0, 8'h11, 0);
    tick("R11 refuse pre", 0, '0, 0, 0, 0, 0, 1);
    idle("R11 run", 8);
    // R12: mode change mid burst does not affect it
    tick("R12 start", 0, '0, 1, 0, 0, 8'h08, 0);
    tick("R12 change", 1, 10'b0_0_0_010_1_001, 0, 0, 0, 0, 0);
    idle("R12 keep", 8);
    tick("R12 new", 0, '0, 1, 0, 0, 8'h08, 0);
    idle("R12 new run", 3);

    // random phase covering R2..R12
    for (int i = 0; i < 6000; i++) begin
      bit ml, cv, cw, cap, pv;
      logic [9:0] mv;
      ml  = ($urandom % 100) < 4;
      mv  = {1'($urandom), 2'b00, ($urandom % 2) ? 3'b011 : 3'b010, 1'($urandom), 3'($urandom)};
      cv  = ($urandom % 100) < 18;
      cw  = 1'($urandom);
      cap = ($urandom % 100) < 25;
      pv  = ($urandom % 100) < 8;
      tick("R2 R8 R9 R11 random", ml, mv, cv, cw, cap, int'($urandom % 256), pv);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule